// File: doc/BRIEF.md
# Two-Requester SRAM Bank Arbiter

This block shares a single synchronous SRAM bank between a processor requester and a backdoor requester. In each cycle it picks at most one of the two requests and drives the bank's enable, write strobe, address and write data from the requester it picked. When a read is granted, the data the bank returns one cycle later is steered to the same requester and marked valid for one cycle.

A 2-bit mode input selects the arbitration policy. Mode 0 is plain alternation. Mode 1 is alternation biased toward the backdoor. Mode 2 gives the processor fixed priority, and mode 3 gives the backdoor fixed priority. A separate write-protect input stops the bank from being written. A write that is granted while protection is set still takes its grant slot, but it never reaches the bank. The requester receives a one-cycle error pulse in place of the write.

The policy history is held in a small state machine with three states:
- `H_CPU_LAST`: the processor was granted most recently. This is also the reset state.
- `H_BD_ONCE`: the backdoor has taken exactly one grant since the processor's last grant.
- `H_BD_TWICE`: the backdoor has taken two or more grants since the processor's last grant.

Its transitions are as follows:
- A processor grant moves any state to `H_CPU_LAST`.
- A backdoor grant moves `H_CPU_LAST` to `H_BD_ONCE`, moves `H_BD_ONCE` to `H_BD_TWICE`, and leaves `H_BD_TWICE` unchanged.
- A cycle with no grant holds the current state.

Top module: `sram_dual_arb`

## Requirements
- R1: In each cycle at most one of `cpu_gnt` and `bd_gnt` is high, and a grant is only given to a requester whose request is high. Grants are combinational, so they appear in the same cycle as the request.
- R2: In every mode, a requester that asserts its request while the other requester does not is granted in that same cycle.
- R3: In mode 2'b00, a contested cycle (both requests high) goes to the requester that was not granted most recently.
- R4: In mode 2'b01, a contested cycle goes to the backdoor unless the two most recent grants both went to the backdoor, in which case it goes to the processor. Under continuous contention the grant pattern is backdoor, backdoor, processor, repeating.
- R5: In mode 2'b10, the processor wins every contested cycle.
- R6: In mode 2'b11, the backdoor wins every contested cycle.
- R7: In a cycle with a grant, `mem_addr`, `mem_wdata` and `mem_we` come from the granted requester, and `mem_en` is high, unless R8 blocks the access. In a cycle with no grant, `mem_en` and `mem_we` are low.
- R8: While `cfg_wprot` is 1, a granted write leaves `mem_en` and `mem_we` low. The error output of the writing requester is high in the following cycle, for that one cycle per blocked write. Reads are not affected by `cfg_wprot`.
- R9: One cycle after a granted read, the granted requester's `*_rvalid` is high and its `*_rdata` equals `mem_rdata`. The other requester's `*_rvalid` stays low. `*_rdata` is zero whenever `*_rvalid` is low.
- R10: Reset clears all valid and error outputs and places the history in `H_CPU_LAST`. As a result, the first contested cycle after reset in mode 2'b00 goes to the backdoor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Arbitration policy select |
| cfg_wprot | input | 1 | Write protect for the bank |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_gnt | output | 1 | Processor granted this cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | DW | Processor read data |
| cpu_err | output | 1 | Processor blocked-write error pulse |
| bd_req | input | 1 | Backdoor request |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | AW | Backdoor word address |
| bd_wdata | input | DW | Backdoor write data |
| bd_gnt | output | 1 | Backdoor granted this cycle |
| bd_rvalid | output | 1 | Backdoor read data valid |
| bd_rdata | output | DW | Backdoor read data |
| bd_err | output | 1 | Backdoor blocked-write error pulse |
| mem_en | output | 1 | Bank access enable |
| mem_we | output | 1 | Bank write strobe |
| mem_addr | output | AW | Bank address |
| mem_wdata | output | DW | Bank write data |
| mem_rdata | input | DW | Bank read data, valid the cycle after a read |

## Verification
The grant and the bank-side signals are due in the same cycle as the request. The bench therefore drives requests at the falling edge and samples them 1 ns later, before the next rising edge. Read returns and error pulses are due exactly one rising edge after the grant. The bench records what it expects at the grant and compares it at the next falling edge, before it drives new stimulus. The bench also computes the expected winner of each contested cycle from its own count of consecutive backdoor grants, for all four modes with protection both off and on.

// File: rtl/sda_pkg.sv
package sda_pkg;

    typedef enum logic [1:0] {
        ARB_RR      = 2'b00,
        ARB_RR_BD   = 2'b01,
        ARB_FIX_CPU = 2'b10,
        ARB_FIX_BD  = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        H_CPU_LAST = 2'b00,
        H_BD_ONCE  = 2'b01,
        H_BD_TWICE = 2'b10
    } hist_e;

    localparam int unsigned NPORT = 2;
    localparam int unsigned P_CPU = 0;
    localparam int unsigned P_BD  = 1;

endpackage

// File: rtl/sda_policy.sv
module sda_policy
    import sda_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       cpu_req,
    input  logic       bd_req,
    output logic       cpu_gnt,
    output logic       bd_gnt
);

    hist_e hist_q, hist_d;
    logic  contest;
    logic  bd_wins;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= H_CPU_LAST;
        else        hist_q <= hist_d;
    end

    // outputs: winner of a contested cycle per policy
    always_comb begin
        contest = cpu_req & bd_req;
        unique case (arb_mode_e'(mode))
            ARB_RR:      bd_wins = (hist_q == H_CPU_LAST);
            ARB_RR_BD:   bd_wins = (hist_q != H_BD_TWICE);
            ARB_FIX_CPU: bd_wins = 1'b0;
            ARB_FIX_BD:  bd_wins = 1'b1;
            default:     bd_wins = 1'b0;
        endcase
        cpu_gnt = cpu_req & ~(contest & bd_wins);
        bd_gnt  = bd_req  & ~(contest & ~bd_wins);
    end

    // next-state: history of grants
    always_comb begin
        hist_d = hist_q;
        if (cpu_gnt) begin
            hist_d = H_CPU_LAST;
        end else if (bd_gnt) begin
            unique case (hist_q)
                H_CPU_LAST: hist_d = H_BD_ONCE;
                H_BD_ONCE:  hist_d = H_BD_TWICE;
                default:    hist_d = H_BD_TWICE;
            endcase
        end
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, bd_gnt}));
    a_r1_cpu_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> cpu_req);
    a_r1_bd_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        bd_gnt |-> bd_req);
    a_r2_lone_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !bd_req) |-> cpu_gnt);
    a_r2_lone_bd: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_req && !cpu_req) |-> bd_gnt);
    a_r3_rr_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && cpu_req && bd_req && $past(cpu_gnt)) |-> bd_gnt);
    a_r5_fix_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && cpu_req) |-> cpu_gnt);
    a_r6_fix_bd: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && bd_req) |-> bd_gnt);

endmodule

// File: rtl/sda_wguard.sv
module sda_wguard #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          wprot,
    input  logic          cpu_gnt,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          bd_gnt,
    input  logic          bd_we,
    input  logic [AW-1:0] bd_addr,
    input  logic [DW-1:0] bd_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          blk_cpu,
    output logic          blk_bd
);

    logic sel_we;
    logic blocked;

    always_comb begin
        if (bd_gnt) begin
            mem_addr  = bd_addr;
            mem_wdata = bd_wdata;
            sel_we    = bd_we;
        end else begin
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
            sel_we    = cpu_we;
        end
        blocked = sel_we & wprot;
        mem_en  = (cpu_gnt | bd_gnt) & ~blocked;
        mem_we  = mem_en & sel_we;
        blk_cpu = cpu_gnt & cpu_we & wprot;
        blk_bd  = bd_gnt & bd_we & wprot;
    end

endmodule

// File: rtl/sda_resp.sv
module sda_resp
    import sda_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] gnt,
    input  logic [NPORT-1:0] we,
    input  logic [NPORT-1:0] blk,
    input  logic [DW-1:0]    mem_rdata,
    output logic [NPORT-1:0] rvalid,
    output logic [NPORT-1:0] err,
    output logic [DW-1:0]    rdata [NPORT]
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic rv_q, err_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rv_q  <= 1'b0;
                err_q <= 1'b0;
            end else begin
                rv_q  <= gnt[p] & ~we[p];
                err_q <= blk[p];
            end
        end

        assign rvalid[p] = rv_q;
        assign err[p]    = err_q;
        assign rdata[p]  = rv_q ? mem_rdata : '0;

        a_r9_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && !we[p]) |=> rvalid[p]);
        a_r8_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
            blk[p] |=> err[p]);
        a_r8_no_err_on_read: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && !we[p]) |=> !err[p]);
    end

    a_r9_single_return: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rvalid));

endmodule

// File: rtl/sram_dual_arb.sv
module sram_dual_arb
    import sda_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_wprot,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_err,
    input  logic          bd_req,
    input  logic          bd_we,
    input  logic [AW-1:0] bd_addr,
    input  logic [DW-1:0] bd_wdata,
    output logic          bd_gnt,
    output logic          bd_rvalid,
    output logic [DW-1:0] bd_rdata,
    output logic          bd_err,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    logic             blk_cpu, blk_bd;
    logic [NPORT-1:0] rv_v, err_v;
    logic [DW-1:0]    rd_v [NPORT];

    sda_policy u_policy (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg_mode),
        .cpu_req (cpu_req),
        .bd_req  (bd_req),
        .cpu_gnt (cpu_gnt),
        .bd_gnt  (bd_gnt)
    );

    sda_wguard #(.AW(AW), .DW(DW)) u_wguard (
        .wprot     (cfg_wprot),
        .cpu_gnt   (cpu_gnt),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .bd_gnt    (bd_gnt),
        .bd_we     (bd_we),
        .bd_addr   (bd_addr),
        .bd_wdata  (bd_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .blk_cpu   (blk_cpu),
        .blk_bd    (blk_bd)
    );

    sda_resp #(.DW(DW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       ({bd_gnt, cpu_gnt}),
        .we        ({bd_we, cpu_we}),
        .blk       ({blk_bd, blk_cpu}),
        .mem_rdata (mem_rdata),
        .rvalid    (rv_v),
        .err       (err_v),
        .rdata     (rd_v)
    );

    assign cpu_rvalid = rv_v[P_CPU];
    assign bd_rvalid  = rv_v[P_BD];
    assign cpu_err    = err_v[P_CPU];
    assign bd_err     = err_v[P_BD];
    assign cpu_rdata  = rd_v[P_CPU];
    assign bd_rdata   = rd_v[P_BD];

    a_r8_no_write_prot: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wprot |-> !mem_we);
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt || bd_gnt) |-> !mem_en);
    a_r7_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

// File: tb/sram_dual_arb_tb.sv
module sram_dual_arb_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_wprot = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          bd_req = 1'b0, bd_we = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [DW-1:0] bd_wdata = '0;
    logic          cpu_gnt, cpu_rvalid, cpu_err, bd_gnt, bd_rvalid, bd_err;
    logic [DW-1:0] cpu_rdata, bd_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    sram_dual_arb #(.AW(AW), .DW(DW)) u_dut (.*);

    // bench-side synchronous SRAM
    logic [DW-1:0] sram [DEPTH];
    logic [DW-1:0] rd_q = '0;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) sram[mem_addr] <= mem_wdata;
            else        rd_q <= sram[mem_addr];
        end
    end
    assign mem_rdata = rd_q;

    logic [DW-1:0] shadow [DEPTH];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog expired act=1 exp=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sram[i]   = DW'(i * 37 + 5);
            shadow[i] = DW'(i * 37 + 5);
        end
        for (int cfg = 0; cfg < 8; cfg++) begin
            int  bd_run;
            bit  e_rv_c, e_rv_b, e_er_c, e_er_b;
            logic [DW-1:0] e_rd;
            cfg_mode  = cfg[1:0];
            cfg_wprot = cfg[2];
            cpu_req = 0; bd_req = 0;
            rst_n = 0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk("R10 reset cpu_rvalid", 32'(cpu_rvalid), 0);
            chk("R10 reset bd_rvalid", 32'(bd_rvalid), 0);
            chk("R10 reset errs", 32'({cpu_err, bd_err}), 0);
            rst_n = 1;
            bd_run = 0;
            e_rv_c = 0; e_rv_b = 0; e_er_c = 0; e_er_b = 0; e_rd = '0;
            for (int n = 0; n < 80; n++) begin
                logic [1:0] r;
                bit exp_c, exp_b, contest, bdw, blk;
                logic [AW-1:0] ga;
                logic [DW-1:0] gd;
                bit gw;
                string tag;
                if (n > 0) @(negedge clk);
                // registered results of the previous cycle
                chk("R9 cpu_rvalid", 32'(cpu_rvalid), 32'(e_rv_c));
                chk("R9 bd_rvalid", 32'(bd_rvalid), 32'(e_rv_b));
                chk("R9 cpu_rdata", 32'(cpu_rdata), e_rv_c ? 32'(e_rd) : 0);
                chk("R9 bd_rdata", 32'(bd_rdata), e_rv_b ? 32'(e_rd) : 0);
                chk("R8 cpu_err", 32'(cpu_err), 32'(e_er_c));
                chk("R8 bd_err", 32'(bd_err), 32'(e_er_b));
                // stimulus
                r = (n < 9) ? 2'b11 : 2'($urandom);
                cpu_req   = r[0];
                bd_req    = r[1];
                cpu_we    = 1'($urandom);
                bd_we     = 1'($urandom);
                cpu_addr  = AW'($urandom);
                bd_addr   = AW'($urandom);
                cpu_wdata = DW'($urandom);
                bd_wdata  = DW'($urandom);
                #1;
                contest = cpu_req && bd_req;
                case (cfg_mode)
                    2'b00: bdw = (bd_run == 0);
                    2'b01: bdw = (bd_run < 2);
                    2'b10: bdw = 0;
                    default: bdw = 1;
                endcase
                exp_c = cpu_req && !(contest && bdw);
                exp_b = bd_req && !(contest && !bdw);
                if (!contest) tag = "R2 lone grant";
                else case (cfg_mode)
                    2'b00: tag = "R3 round robin";
                    2'b01: tag = "R4 biased rr";
                    2'b10: tag = "R5 fixed cpu";
                    default: tag = "R6 fixed bd";
                endcase
                chk({tag, " cpu_gnt"}, 32'(cpu_gnt), 32'(exp_c));
                chk({tag, " bd_gnt"}, 32'(bd_gnt), 32'(exp_b));
                chk("R1 onehot", 32'(cpu_gnt & bd_gnt), 0);
                if (n == 0 && cfg_mode == 2'b00)
                    chk("R10 first contest to bd", 32'(bd_gnt), 1);
                ga = exp_b ? bd_addr : cpu_addr;
                gd = exp_b ? bd_wdata : cpu_wdata;
                gw = exp_b ? bd_we : cpu_we;
                blk = (exp_c || exp_b) && gw && cfg_wprot;
                chk("R7 mem_en", 32'(mem_en), 32'((exp_c || exp_b) && !blk));
                chk("R8 mem_we", 32'(mem_we), 32'((exp_c || exp_b) && gw && !cfg_wprot));
                if (exp_c || exp_b) begin
                    chk("R7 mem_addr", 32'(mem_addr), 32'(ga));
                    if (gw && !cfg_wprot) chk("R7 mem_wdata", 32'(mem_wdata), 32'(gd));
                end
                // expectations for the next cycle
                e_rv_c = exp_c && !cpu_we;
                e_rv_b = exp_b && !bd_we;
                e_er_c = exp_c && cpu_we && cfg_wprot;
                e_er_b = exp_b && bd_we && cfg_wprot;
                e_rd   = shadow[ga];
                if ((exp_c || exp_b) && gw && !cfg_wprot) shadow[ga] = gd;
                if (exp_c) bd_run = 0;
                else if (exp_b && bd_run < 2) bd_run++;
            end
            @(negedge clk);
            chk("R9 final cpu_rvalid", 32'(cpu_rvalid), 32'(e_rv_c));
            chk("R8 final bd_err", 32'(bd_err), 32'(e_er_b));
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule